// File: doc/BRIEF.md
# Masked Vector Gather Load Sequencer

The sequencer loads 32-bit elements from scattered memory locations into a vector destination register. Each element address is formed from one scalar base address plus one signed index taken from an index vector, shifted left by a scale factor. One read is issued per enabled element over a valid/ready request port. The returned word is merged into the destination at that element's position.

The mask vector does two jobs. It selects the elements to load, and it records progress. Each element's mask is cleared as its data arrives. If a read returns an error, the sequencer stops and reports the element that faulted. The partially updated destination and mask can then be fed back in to resume the gather where it stopped. Index width (32 or 64 bits) and vector length (full or half) decide how many lanes take part. Lanes outside that count are zeroed in both registers.

Top module: `gather_unit`

## Requirements
- R1: The address of element i is base_i plus the sign-extended index shifted left by scale_i (code 0..3 gives x1, x2, x4, x8), truncated to ADDR_W bits. With qidx_i=0 the index of lane i is idx_i[32i+31:32i]. With qidx_i=1 it is idx_i[64i+63:64i].
- R2: Element i is enabled only when bit 31 of its 32-bit mask lane, mask_i[32i+31], is set. A disabled lane causes no request, and its destination lane is returned unchanged.
- R3: Enabled lanes are requested in ascending lane order, one request outstanding at a time, and each address is issued exactly once.
- R4: The number of participating lanes is 8 for qidx_i=0/wide_i=1, 4 for qidx_i=0/wide_i=0, 4 for qidx_i=1/wide_i=1 and 2 for qidx_i=1/wide_i=0.
- R5: Every lane at or above the participating count reads zero in both dst_o and mask_o once done_o pulses, including when the operation faults.
- R6: When every enabled lane loads without error, done_o pulses with fault_o low, mask_o is all zero, and each loaded lane holds its response word.
- R7: An error response ends the operation. done_o pulses with fault_o high and fault_lane_o set to the faulting lane. Lanes loaded before the fault hold their data with a zero mask. The faulting lane and all later lanes keep their mask and destination values.
- R8: When no participating lane is enabled, done_o pulses in the first cycle after start, busy_o never rises and no request is made.
- R9: A request that is not accepted keeps mem_req_valid_o high and mem_req_addr_o unchanged.
- R10: busy_o is high from the cycle after an accepted start until the cycle done_o pulses, in which it is low. start_i is ignored while busy_o is high, and no request is made while busy_o is low.
- R11: Feeding dst_o and mask_o from a faulted operation back in as dst_i and mask_i loads exactly the lanes that were not yet gathered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; operands are sampled with it |
| dst_i | input | LANES*32 | Destination register before the operation |
| mask_i | input | LANES*32 | Mask register before the operation |
| base_i | input | ADDR_W | Common base address |
| idx_i | input | LANES*32 | Index vector, 32-bit or 64-bit signed lanes |
| scale_i | input | 2 | Scale code, shift of 0 to 3 |
| qidx_i | input | 1 | 1: 64-bit indices, 0: 32-bit indices |
| wide_i | input | 1 | 1: full vector length, 0: half length |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | Last operation ended on an error response |
| fault_lane_o | output | $clog2(LANES) | Lane that faulted |
| dst_o | output | LANES*32 | Updated destination register |
| mask_o | output | LANES*32 | Updated mask register |
| mem_req_valid_o | output | 1 | Read request valid |
| mem_req_ready_i | input | 1 | Read request accepted |
| mem_req_addr_o | output | ADDR_W | Read address |
| mem_rsp_valid_i | input | 1 | Read response valid |
| mem_rsp_data_i | input | 32 | Read response data |
| mem_rsp_err_i | input | 1 | Read response error |

## Verification
Several properties are checked on every cycle: a request holds its address while it stalls, there is no request while idle, busy and done are never high together, a lane's mask is cleared after its good response, a success leaves the mask empty, a fault leaves the faulting lane's mask set, and lanes beyond the count are zero at completion. Only the bench scenarios can show that the addresses come out in the right order with correct sign extension and scaling. The same holds for the lane count under each width combination, the loaded data, the lanes left untouched, the one-cycle finish with an empty mask, and a resumed gather finishing exactly the remaining lanes.

// File: rtl/gather_pkg.sv
package gather_pkg;

    localparam int ELEM_W  = 32;
    localparam int DIDX_W  = 32;
    localparam int QIDX_W  = 64;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        SCL_X1 = 2'd0,
        SCL_X2 = 2'd1,
        SCL_X4 = 2'd2,
        SCL_X8 = 2'd3
    } scale_e;

    typedef struct packed {
        scale_e scale;
        logic   qidx;
        logic   wide;
    } gather_cfg_t;

    // Number of lanes that take part for a given index width and length.
    function automatic int active_lanes(int lanes, logic qidx, logic wide);
        int n;
        n = wide ? lanes : lanes / 2;
        if (qidx) n = n / 2;
        return n;
    endfunction

endpackage

// File: rtl/gather_lane_pick.sv
module gather_lane_pick #(
    parameter int LANES = 8
) (
    input  logic [LANES-1:0]         cand,
    output logic                     found,
    output logic [$clog2(LANES)-1:0] lane
);
    localparam int LW = $clog2(LANES);

    // Lowest set candidate wins.
    always_comb begin
        found = 1'b0;
        lane  = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found = 1'b1;
                lane  = LW'(i);
            end
        end
    end
endmodule

// File: rtl/gather_addr_gen.sv
module gather_addr_gen
    import gather_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int ADDR_W = 48
) (
    input  logic [LANES*DIDX_W-1:0]  idx_vec,
    input  gather_cfg_t              cfg,
    input  logic [ADDR_W-1:0]        base,
    input  logic [$clog2(LANES)-1:0] lane,
    output logic [ADDR_W-1:0]        addr
);
    localparam int QLANES = LANES / 2;

    logic [QIDX_W-1:0] idx_ext [LANES];
    logic [QIDX_W-1:0] sel;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            logic [QIDX_W-1:0] dw_ext;
            logic [QIDX_W-1:0] qw_ext;
            assign dw_ext = {{(QIDX_W-DIDX_W){idx_vec[DIDX_W*g+DIDX_W-1]}},
                             idx_vec[DIDX_W*g +: DIDX_W]};
            if (g < QLANES) begin : g_q
                assign qw_ext = idx_vec[QIDX_W*g +: QIDX_W];
            end else begin : g_nq
                assign qw_ext = '0;
            end
            assign idx_ext[g] = cfg.qidx ? qw_ext : dw_ext;
        end
    endgenerate

    assign sel  = idx_ext[lane];
    assign addr = ADDR_W'({{(QIDX_W-ADDR_W){1'b0}}, base} + (sel << cfg.scale));
endmodule

// File: rtl/gather_elem_regs.sv
module gather_elem_regs
    import gather_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load,
    input  logic [LANES-1:0]         lane_keep,
    input  logic [LANES*ELEM_W-1:0]  dst_in,
    input  logic [LANES*ELEM_W-1:0]  mask_in,
    input  logic                     wr_en,
    input  logic [$clog2(LANES)-1:0] wr_lane,
    input  logic [ELEM_W-1:0]        wr_data,
    input  logic                     clr_mask,
    output logic [LANES*ELEM_W-1:0]  dst_q,
    output logic [LANES*ELEM_W-1:0]  mask_q
);
    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            logic [ELEM_W-1:0] d_r;
            logic [ELEM_W-1:0] m_r;
            always_ff @(posedge clk) begin
                if (rst) begin
                    d_r <= '0;
                    m_r <= '0;
                end else begin
                    if (load) begin
                        d_r <= lane_keep[g] ? dst_in[ELEM_W*g +: ELEM_W]  : '0;
                        m_r <= lane_keep[g] ? mask_in[ELEM_W*g +: ELEM_W] : '0;
                    end else if (wr_en && (wr_lane == g)) begin
                        d_r <= wr_data;
                        m_r <= '0;
                    end
                    if (clr_mask) m_r <= '0;
                end
            end
            assign dst_q[ELEM_W*g +: ELEM_W]  = d_r;
            assign mask_q[ELEM_W*g +: ELEM_W] = m_r;
        end
    endgenerate
endmodule

// File: rtl/gather_unit.sv
module gather_unit
    import gather_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int ADDR_W = 48
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start_i,
    input  logic [LANES*32-1:0]      dst_i,
    input  logic [LANES*32-1:0]      mask_i,
    input  logic [ADDR_W-1:0]        base_i,
    input  logic [LANES*32-1:0]      idx_i,
    input  logic [1:0]               scale_i,
    input  logic                     qidx_i,
    input  logic                     wide_i,
    output logic                     busy_o,
    output logic                     done_o,
    output logic                     fault_o,
    output logic [$clog2(LANES)-1:0] fault_lane_o,
    output logic [LANES*32-1:0]      dst_o,
    output logic [LANES*32-1:0]      mask_o,
    output logic                     mem_req_valid_o,
    input  logic                     mem_req_ready_i,
    output logic [ADDR_W-1:0]        mem_req_addr_o,
    input  logic                     mem_rsp_valid_i,
    input  logic [31:0]              mem_rsp_data_i,
    input  logic                     mem_rsp_err_i
);
    localparam int LW = $clog2(LANES);

    seq_state_e        state;
    gather_cfg_t       cfg_r;
    logic [ADDR_W-1:0] base_r;
    logic [LANES*32-1:0] idx_r;
    logic [LW-1:0]     lane_r;
    logic              done_r;
    logic              fault_r;
    logic [LW-1:0]     flane_r;

    logic [LANES-1:0]  lane_keep;
    logic [LANES-1:0]  msb_in;
    logic [LANES-1:0]  msb_q;
    logic [LANES-1:0]  pick_cand;
    logic              pick_found;
    logic [LW-1:0]     pick_lane;
    logic              start_go;
    logic              rsp_ok;
    logic              rsp_bad;
    logic              clr_mask;
    logic [LANES*32-1:0] dst_q;
    logic [LANES*32-1:0] mask_q;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_msb
            assign lane_keep[g] = (g < active_lanes(LANES, qidx_i, wide_i));
            assign msb_in[g]    = mask_i[ELEM_W*g + ELEM_W-1] & lane_keep[g];
            assign msb_q[g]     = mask_q[ELEM_W*g + ELEM_W-1];
        end
    endgenerate

    assign start_go  = (state == ST_IDLE) && start_i;
    assign rsp_ok    = (state == ST_WAIT) && mem_rsp_valid_i && !mem_rsp_err_i;
    assign rsp_bad   = (state == ST_WAIT) && mem_rsp_valid_i &&  mem_rsp_err_i;
    assign pick_cand = (state == ST_IDLE) ? msb_in
                                          : (msb_q & ~(LANES'(1) << lane_r));
    assign clr_mask  = (start_go || rsp_ok) && !pick_found;

    gather_lane_pick #(.LANES(LANES)) u_pick (
        .cand  (pick_cand),
        .found (pick_found),
        .lane  (pick_lane)
    );

    gather_addr_gen #(.LANES(LANES), .ADDR_W(ADDR_W)) u_addr (
        .idx_vec (idx_r),
        .cfg     (cfg_r),
        .base    (base_r),
        .lane    (lane_r),
        .addr    (mem_req_addr_o)
    );

    gather_elem_regs #(.LANES(LANES)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .load      (start_go),
        .lane_keep (lane_keep),
        .dst_in    (dst_i),
        .mask_in   (mask_i),
        .wr_en     (rsp_ok),
        .wr_lane   (lane_r),
        .wr_data   (mem_rsp_data_i),
        .clr_mask  (clr_mask),
        .dst_q     (dst_q),
        .mask_q    (mask_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cfg_r   <= '0;
            base_r  <= '0;
            idx_r   <= '0;
            lane_r  <= '0;
            done_r  <= 1'b0;
            fault_r <= 1'b0;
            flane_r <= '0;
        end else begin
            done_r <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        cfg_r   <= '{scale: scale_e'(scale_i), qidx: qidx_i, wide: wide_i};
                        base_r  <= base_i;
                        idx_r   <= idx_i;
                        fault_r <= 1'b0;
                        if (pick_found) begin
                            lane_r <= pick_lane;
                            state  <= ST_REQ;
                        end else begin
                            done_r <= 1'b1;
                        end
                    end
                end
                ST_REQ: begin
                    if (mem_req_ready_i) state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (rsp_bad) begin
                        fault_r <= 1'b1;
                        flane_r <= lane_r;
                        done_r  <= 1'b1;
                        state   <= ST_IDLE;
                    end else if (rsp_ok) begin
                        if (pick_found) begin
                            lane_r <= pick_lane;
                            state  <= ST_REQ;
                        end else begin
                            done_r <= 1'b1;
                            state  <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy_o          = (state != ST_IDLE);
    assign done_o          = done_r;
    assign fault_o         = fault_r;
    assign fault_lane_o    = flane_r;
    assign dst_o           = dst_q;
    assign mask_o          = mask_q;
    assign mem_req_valid_o = (state == ST_REQ);
endmodule

// File: rtl/gather_unit_chk.sv
module gather_unit_chk
    import gather_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int ADDR_W = 48
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     busy_o,
    input logic                     done_o,
    input logic                     fault_o,
    input logic [$clog2(LANES)-1:0] fault_lane_o,
    input logic [LANES*32-1:0]      dst_o,
    input logic [LANES*32-1:0]      mask_o,
    input logic                     mem_req_valid_o,
    input logic                     mem_req_ready_i,
    input logic [ADDR_W-1:0]        mem_req_addr_o,
    input logic                     mem_rsp_valid_i,
    input logic                     mem_rsp_err_i,
    input logic [$clog2(LANES)-1:0] cur_lane,
    input logic                     cfg_qidx,
    input logic                     cfg_wide
);
    logic beyond_zero;
    always_comb begin
        beyond_zero = 1'b1;
        for (int g = 0; g < LANES; g++) begin
            if (g >= active_lanes(LANES, cfg_qidx, cfg_wide) &&
                ((dst_o[32*g +: 32] != '0) || (mask_o[32*g +: 32] != '0)))
                beyond_zero = 1'b0;
        end
    end

    p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));

    p_idle_no_req_r10: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !mem_req_valid_o);

    p_done_not_busy_r10: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    p_lane_cleared_r2: assert property (@(posedge clk) disable iff (rst)
        busy_o && !mem_req_valid_o && mem_rsp_valid_i && !mem_rsp_err_i
        |=> !mask_o[{$past(cur_lane), 5'd31}]);

    p_success_mask_zero_r6: assert property (@(posedge clk) disable iff (rst)
        done_o && !fault_o |-> mask_o == '0);

    p_fault_lane_kept_r7: assert property (@(posedge clk) disable iff (rst)
        done_o && fault_o |-> mask_o[{fault_lane_o, 5'd31}]);

    p_upper_zero_r5: assert property (@(posedge clk) disable iff (rst)
        done_o |-> beyond_zero);
endmodule

bind gather_unit gather_unit_chk #(.LANES(LANES), .ADDR_W(ADDR_W)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .busy_o          (busy_o),
    .done_o          (done_o),
    .fault_o         (fault_o),
    .fault_lane_o    (fault_lane_o),
    .dst_o           (dst_o),
    .mask_o          (mask_o),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_req_addr_o  (mem_req_addr_o),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .mem_rsp_err_i   (mem_rsp_err_i),
    .cur_lane        (lane_r),
    .cfg_qidx        (cfg_r.qidx),
    .cfg_wide        (cfg_r.wide)
);

// File: tb/gather_unit_tb.sv
module gather_unit_tb;
    localparam int LANES  = 8;
    localparam int ADDR_W = 48;
    localparam int VW     = LANES * 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;  // 125 MHz

    logic              start_i = 1'b0;
    logic [VW-1:0]     dst_i = '0, mask_i = '0, idx_i = '0;
    logic [ADDR_W-1:0] base_i = '0;
    logic [1:0]        scale_i = '0;
    logic              qidx_i = 1'b0, wide_i = 1'b0;
    logic              busy_o, done_o, fault_o;
    logic [2:0]        fault_lane_o;
    logic [VW-1:0]     dst_o, mask_o;
    logic              mem_req_valid_o;
    logic              mem_req_ready_i = 1'b0;
    logic [ADDR_W-1:0] mem_req_addr_o;
    logic              mem_rsp_valid_i = 1'b0;
    logic [31:0]       mem_rsp_data_i = '0;
    logic              mem_rsp_err_i = 1'b0;

    gather_unit #(.LANES(LANES), .ADDR_W(ADDR_W)) u_dut (.*);

    int total = 0;
    int failed = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [VW-1:0] act, input logic [VW-1:0] exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mem_word(input logic [ADDR_W-1:0] a);
        return {a[15:0], a[31:16]} ^ 32'hC3A5_0F1E;
    endfunction

    // Memory responder state
    logic [ADDR_W-1:0] exp_q[$];
    bit                stall_mode = 0;
    int                lat = 1;
    bit                fault_en = 0;
    logic [ADDR_W-1:0] fault_addr = '0;
    int                rsp_cnt = 0;
    logic [ADDR_W-1:0] pend_addr = '0;
    int                cyc = 0;

    always @(negedge clk) begin
        cyc++;
        mem_rsp_valid_i = 1'b0;
        mem_rsp_err_i   = 1'b0;
        if (!rst) begin
            if (rsp_cnt > 0) begin
                rsp_cnt--;
                if (rsp_cnt == 0) begin
                    mem_rsp_valid_i = 1'b1;
                    mem_rsp_data_i  = mem_word(pend_addr);
                    mem_rsp_err_i   = fault_en && (pend_addr == fault_addr);
                end
            end
            mem_req_ready_i = stall_mode ? (cyc % 3 == 0) : 1'b1;
            if (mem_req_valid_o && mem_req_ready_i) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R3", "unexpected request", VW'(mem_req_addr_o), '0);
                end else begin
                    logic [ADDR_W-1:0] e;
                    e = exp_q.pop_front();
                    chk(mem_req_addr_o == e, "R1", "request address",
                        VW'(mem_req_addr_o), VW'(e));
                end
                pend_addr = mem_req_addr_o;
                rsp_cnt   = lat;
            end
        end
    end

    // Reference model of one whole operation; fills the expected address queue.
    task automatic run_op(input logic [VW-1:0] d, input logic [VW-1:0] m,
                          input logic [ADDR_W-1:0] b, input logic [VW-1:0] ix,
                          input logic [1:0] sc, input logic q, input logic w,
                          input bit mid_start, input string tag);
        int n;
        logic [VW-1:0] ed, em;
        bit efault, any;
        int elane;
        int k;
        bit got;
        n = w ? LANES : LANES / 2;
        if (q) n = n / 2;
        ed = d; em = m; efault = 0; elane = 0; any = 0;
        exp_q.delete();
        for (int i = 0; i < LANES; i++) begin
            if (i >= n) begin
                ed[32*i +: 32] = '0;
                em[32*i +: 32] = '0;
            end
        end
        for (int i = 0; i < n; i++) begin
            if (m[32*i+31] && !efault) begin
                logic [63:0] iv;
                logic [ADDR_W-1:0] a;
                any = 1;
                iv = q ? ix[64*i +: 64] : {{32{ix[32*i+31]}}, ix[32*i +: 32]};
                a  = ADDR_W'({16'h0, b} + (iv << sc));
                exp_q.push_back(a);
                if (fault_en && a == fault_addr) begin
                    efault = 1;
                    elane = i;
                end else begin
                    ed[32*i +: 32] = mem_word(a);
                    em[32*i +: 32] = '0;
                end
            end
        end
        if (!efault) em = '0;

        dst_i = d; mask_i = m; base_i = b; idx_i = ix; scale_i = sc;
        qidx_i = q; wide_i = w; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        k = 0; got = 0;
        while (!got && k < 2000) begin
            if (done_o) begin
                got = 1;
                chk(!busy_o, "R10", {tag, " busy low with done"}, VW'(busy_o), '0);
                if (!any)
                    chk(k == 0, "R8", {tag, " done latency"}, VW'(k), '0);
            end else begin
                chk(busy_o && any, "R10", {tag, " busy while running"}, VW'(busy_o), VW'(1));
                if (mid_start && k == 2) begin
                    start_i = 1'b1; mask_i = '1; base_i = '0; idx_i = '1;
                end else begin
                    start_i = 1'b0;
                end
                k++;
                @(negedge clk);
            end
        end
        start_i = 1'b0;
        chk(got, "R6", {tag, " completion seen"}, VW'(got), VW'(1));
        chk(dst_o == ed, efault ? "R7" : "R6", {tag, " dst"}, dst_o, ed);
        chk(mask_o == em, efault ? "R7" : "R5", {tag, " mask"}, mask_o, em);
        chk(fault_o == efault, "R7", {tag, " fault flag"}, VW'(fault_o), VW'(efault));
        if (efault)
            chk(fault_lane_o == elane, "R7", {tag, " fault lane"}, VW'(fault_lane_o), VW'(elane));
        chk(exp_q.size() == 0, "R3", {tag, " all requests issued"}, VW'(exp_q.size()), '0);
        @(negedge clk);
    endtask

    function automatic logic [VW-1:0] pat(input logic [31:0] seed);
        logic [VW-1:0] v;
        for (int i = 0; i < LANES; i++) v[32*i +: 32] = seed + 32'h0101_0101 * i;
        return v;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        failed++; total++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        logic [VW-1:0] ix, m;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        chk(!busy_o && !done_o && !mem_req_valid_o, "R10", "reset idle",
            VW'({busy_o, done_o, mem_req_valid_o}), '0);
        chk(dst_o == '0 && mask_o == '0, "R5", "reset registers", dst_o | mask_o, '0);

        // R1 R4 R6: dword, full length, all lanes, scale x4
        for (int i = 0; i < LANES; i++) ix[32*i +: 32] = 32'(i * 3);
        run_op(pat(32'h1111_0000), '1, 48'h0000_4000_0000, ix, 2'd2, 0, 1, 0, "dw-full");

        // R2 R4 R5: dword half length, sparse mask, negative indices, stalls, x1
        stall_mode = 1; lat = 3;
        m = '1; m[32*1+31] = 1'b0;
        for (int i = 0; i < LANES; i++) ix[32*i +: 32] = -32'(i * 5 + 1);
        run_op(pat(32'hA000_0000), m, 48'h0000_1000_0000, ix, 2'd0, 0, 0, 0, "dw-half");

        // R1 R4 R5: qword full length, lanes 1 and 3, x8
        stall_mode = 0; lat = 2;
        m = '0; m[32*1+31] = 1'b1; m[32*3+31] = 1'b1; m[32*0 +: 31] = '1;
        ix = '0;
        ix[64*0 +: 64] = 64'd7; ix[64*1 +: 64] = -64'd2;
        ix[64*2 +: 64] = 64'd9; ix[64*3 +: 64] = 64'h0000_0001_0000_0000;
        run_op(pat(32'h5500_0000), m, 48'h0000_0800_0000, ix, 2'd3, 1, 1, 0, "qw-full");

        // R4: qword half length
        run_op(pat(32'h7700_0000), '1, 48'h0000_0000_2000, ix, 2'd1, 1, 0, 0, "qw-half");

        // R8: no enabled lane, lower bits set
        m = '0; for (int i = 0; i < LANES; i++) m[32*i +: 31] = '1;
        run_op(pat(32'h3300_0000), m, 48'h0, ix, 2'd0, 0, 1, 0, "empty");

        // R7: fault on lane 5 of a full dword gather
        for (int i = 0; i < LANES; i++) ix[32*i +: 32] = 32'(i * 16);
        fault_en = 1; fault_addr = 48'h0000_9000_0000 + 48'(5 * 16 * 2);
        run_op(pat(32'h2200_0000), '1, 48'h0000_9000_0000, ix, 2'd1, 0, 1, 0, "fault-mid");

        // R11: resume from the partial state
        fault_en = 0;
        run_op(dst_o, mask_o, 48'h0000_9000_0000, ix, 2'd1, 0, 1, 0, "resume");

        // R5 R7: fault on first lane of a half-length gather
        fault_en = 1; fault_addr = 48'h0000_9000_0000;
        run_op(pat(32'h4400_0000), '1, 48'h0000_9000_0000, ix, 2'd1, 0, 0, 0, "fault-first");

        // R10: start while busy is ignored
        fault_en = 0; stall_mode = 1; lat = 1;
        run_op(pat(32'h6600_0000), '1, 48'h0000_0000_0100, ix, 2'd2, 0, 1, 1, "start-busy");

        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule